// File: doc/BRIEF.md
# Show-Ahead Sample FIFO with Bypass

This block sits in the output data path of a sampling converter. Each completed conversion delivers one 18-bit word: 16 sample bits, a duplicate of the sample's most significant bit and an over-range flag. A path-select input chooses between two routes. In buffered mode, every finished conversion is pushed into a 16-entry queue, and the oldest unread word is presented on the output at all times. In bypass mode, the incoming word passes straight to the output and the queue is frozen.

Reading is controlled by an asynchronous strobe. Each rising edge moves the output on to the next stored word. After the final stored word has been presented, the next falling edge marks the queue empty. From then on the output keeps showing that last word until new data arrives. A two-bit fill code reports the occupancy. Driving path-select low while the strobe is also low empties the queue. Both path-select and the strobe are brought into the clock domain through two-flop synchronizers, and strobe edges are detected after synchronization.

Top module: `sample_fifo_bypass`

## Requirements
- R1: With path_sel low (after synchronization), out_word equals conv_word combinationally.
- R2: In bypass mode, conv_done pulses are ignored: the fill code and stored words are unchanged when buffered mode resumes, as long as rd_strobe stays high.
- R3: In buffered mode, every conv_done pulse stores conv_word, whether rd_strobe is high or low.
- R4: A word written into an empty queue appears on out_word one clock after the write, without any strobe edge.
- R5: Each synchronized rising edge of rd_strobe, taken while two or more words are held, drops the head word and presents the next one. Sixteen stored words are therefore walked through with 15 rising edges.
- R6: A conv_done pulse while 16 words are held is discarded. The stored contents and the fill code do not change.
- R7: fill_status encodes occupancy: 2'b01 for none, 2'b00 for 1 to 7 words, 2'b10 for 8 to 15 words, and 2'b11 for 16 words.
- R8: With exactly one word held, a falling edge of rd_strobe sets fill_status to 2'b01.
- R9: While the queue is empty in buffered mode, strobe edges leave out_word showing the last word that was presented.
- R10: path_sel low together with rd_strobe low (both synchronized) clears the queue to empty. The next written word then becomes the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| conv_done | input | 1 | One-cycle pulse marking a completed conversion, synchronous to clk |
| conv_word | input | 18 | Conversion word: {over-range, MSB copy, 16 data bits} |
| path_sel | input | 1 | 1 = buffered, 0 = bypass; asynchronous |
| rd_strobe | input | 1 | Asynchronous read strobe |
| out_word | output | 18 | Presented word |
| fill_status | output | 2 | Occupancy code (R7) |

## Verification
A conv_done pulse captured at one edge updates out_word and fill_status right after that edge. The bench checks these at the following falling edge. A strobe change goes through two synchronizer flops and one edge-detect flop before the state register takes it, so its effect appears after the third rising edge. The bench waits four edges after every strobe or path-select change and samples at a falling edge. A path-select change reaches the bypass multiplexer after two edges, and a change of conv_word in bypass mode is checked one time unit after it is driven.

// File: rtl/sfb_pkg.sv
package sfb_pkg;
  localparam logic [1:0] FILL_NONE = 2'b01;
  localparam logic [1:0] FILL_LOW  = 2'b00;
  localparam logic [1:0] FILL_HALF = 2'b10;
  localparam logic [1:0] FILL_ALL  = 2'b11;

  // Occupancy to fill code; half threshold is depth/2.
  function automatic logic [1:0] fill_code(input int unsigned occ,
                                           input int unsigned depth);
    if (occ == 0)               return FILL_NONE;
    else if (occ >= depth)      return FILL_ALL;
    else if (occ >= depth / 2)  return FILL_HALF;
    else                        return FILL_LOW;
  endfunction
endpackage

// File: rtl/sfb_sync.sv
module sfb_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      stage_q[s] <= '0;
        else if (s == 0) stage_q[s] <= async_in;
        else             stage_q[s] <= stage_q[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/sfb_edge.sv
module sfb_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise,
  output logic fall
);
  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level;
  end

  assign rise = level & ~level_q;
  assign fall = ~level & level_q;
endmodule

// File: rtl/sfb_store.sv
module sfb_store #(
  parameter int WORD_W = 18,
  parameter int DEPTH  = 16,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              push,
  input  logic              pop,
  input  logic [WORD_W-1:0] wr_word,
  output logic [WORD_W-1:0] head,
  output logic [CNT_W-1:0]  occ
);
  localparam logic [PTR_W-1:0] LAST_P = PTR_W'(DEPTH - 1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST_P) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else if (clear) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      case ({push, pop})
        2'b10:   occ <= occ + 1'b1;
        2'b01:   occ <= occ - 1'b1;
        default: occ <= occ;
      endcase
    end
  end

  assign head = mem[rd_ptr];
endmodule

// File: rtl/sample_fifo_bypass.sv
module sample_fifo_bypass
  import sfb_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int DEPTH       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int WORD_W     = DATA_W + 2,
  localparam int CNT_W      = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_done,
  input  logic [WORD_W-1:0] conv_word,
  input  logic              path_sel,
  input  logic              rd_strobe,
  output logic [WORD_W-1:0] out_word,
  output logic [1:0]        fill_status
);
  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

  logic [1:0]        sync_bus;
  logic              mode_s, strobe_s;
  logic              rd_rise, rd_fall;
  logic              clear_w, push_w, pop_w, full_w, last_w;
  logic [WORD_W-1:0] head_w, hold_q, fifo_word;
  logic [CNT_W-1:0]  occ_w;

  sfb_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({path_sel, rd_strobe}),
    .sync_out (sync_bus)
  );
  assign mode_s   = sync_bus[1];
  assign strobe_s = sync_bus[0];

  sfb_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .level (strobe_s),
    .rise  (rd_rise),
    .fall  (rd_fall)
  );

  // Named events used by the queue and by the checker.
  assign clear_w = ~mode_s & ~strobe_s;
  assign full_w  = (occ_w == FULL_C);
  assign last_w  = (occ_w == ONE_C);
  assign push_w  = mode_s & conv_done & ~full_w;
  assign pop_w   = mode_s & ((rd_rise & (occ_w > ONE_C)) | (rd_fall & last_w));

  sfb_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (clear_w),
    .push    (push_w),
    .pop     (pop_w),
    .wr_word (conv_word),
    .head    (head_w),
    .occ     (occ_w)
  );

  // Last presented word, kept once the queue drains.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              hold_q <= '0;
    else if (pop_w & last_w) hold_q <= head_w;
  end

  assign fifo_word   = (occ_w != '0) ? head_w : hold_q;
  assign out_word    = mode_s ? fifo_word : conv_word;
  assign fill_status = fill_code(32'(occ_w), DEPTH);
endmodule

// File: rtl/sfb_checker.sv
module sfb_checker #(
  parameter int WORD_W = 18,
  parameter int DEPTH  = 16,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_s,
  input logic              clear,
  input logic              push,
  input logic              pop,
  input logic [CNT_W-1:0]  occ,
  input logic [WORD_W-1:0] din,
  input logic [WORD_W-1:0] dout,
  input logic [1:0]        status
);
  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

  assert_bypass_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_s |-> dout == din);

  assert_bypass_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_s && !clear) |=> occ == $past(occ));

  assert_show_ahead_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (push && occ == '0) |=> (!mode_s || dout == $past(din)));

  assert_full_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == FULL_C && !pop && !clear) |=> occ == FULL_C);

  assert_full_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    status == 2'b11 |-> occ == FULL_C);

  assert_empty_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
    occ == '0 |-> status == 2'b01);

  assert_last_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && occ == ONE_C && !push) |=> status == 2'b01);

  assert_empty_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_s && occ == '0 && !push) |=> (!mode_s || $stable(dout)));

  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> status == 2'b01);
endmodule

bind sample_fifo_bypass sfb_checker #(
  .WORD_W (WORD_W),
  .DEPTH  (DEPTH),
  .CNT_W  (CNT_W)
) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .mode_s (mode_s),
  .clear  (clear_w),
  .push   (push_w),
  .pop    (pop_w),
  .occ    (occ_w),
  .din    (conv_word),
  .dout   (out_word),
  .status (fill_status)
);

// File: tb/sample_fifo_bypass_test.sv
module sample_fifo_bypass_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_done = 1'b0;
  logic [17:0] conv_word = '0;
  logic        path_sel = 1'b1;
  logic        rd_strobe = 1'b1;
  logic [17:0] out_word;
  logic [1:0]  fill_status;

  int vecs = 0;
  int errs = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sample_fifo_bypass uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .conv_done   (conv_done),
    .conv_word   (conv_word),
    .path_sel    (path_sel),
    .rd_strobe   (rd_strobe),
    .out_word    (out_word),
    .fill_status (fill_status)
  );

  task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic write_word(input logic [17:0] w);
    conv_word = w;
    conv_done = 1'b1;
    @(posedge clk);
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  task automatic set_strobe(input logic v);
    rd_strobe = v;
    tick(4);
  endtask

  task automatic set_mode(input logic v);
    path_sel = v;
    tick(4);
  endtask

  task automatic t_reset;
    check("R7 reset empty code", {16'h0, fill_status}, 18'h1);
    check("R9 reset output", out_word, 18'h0);
  endtask

  task automatic t_bypass;
    set_mode(1'b0);
    conv_word = 18'h2A5A5;
    #1;
    check("R1 bypass word", out_word, 18'h2A5A5);
    conv_word = 18'h15A5A;
    #1;
    check("R1 bypass follows", out_word, 18'h15A5A);
    tick(1);
    write_word(18'h0BEEF);
    write_word(18'h0CAFE);
    check("R2 bypass writes ignored", {16'h0, fill_status}, 18'h1);
    set_mode(1'b1);
    check("R2 no data after bypass", out_word, 18'h0);
    check("R2 still empty", {16'h0, fill_status}, 18'h1);
  endtask

  task automatic t_show_ahead;
    write_word(18'h10001);
    check("R4 head shown", out_word, 18'h10001);
    write_word(18'h10002);
    check("R7 two words low code", {16'h0, fill_status}, 18'h0);
    set_strobe(1'b0);
    check("R5 fall with two words no move", out_word, 18'h10001);
    write_word(18'h10003);
    check("R3 write while strobe low", {16'h0, fill_status}, 18'h0);
    check("R4 head unchanged", out_word, 18'h10001);
    set_strobe(1'b1);
    check("R5 first rise", out_word, 18'h10002);
    set_strobe(1'b0);
    set_strobe(1'b1);
    check("R5 second rise", out_word, 18'h10003);
    check("R8 one word not empty", {16'h0, fill_status}, 18'h0);
    set_strobe(1'b0);
    check("R8 fall at last word empties", {16'h0, fill_status}, 18'h1);
    check("R9 last word held", out_word, 18'h10003);
    set_strobe(1'b1);
    set_strobe(1'b0);
    check("R9 read when empty holds", out_word, 18'h10003);
    check("R9 still empty", {16'h0, fill_status}, 18'h1);
  endtask

  task automatic t_full;
    set_strobe(1'b1);
    for (int k = 0; k < 16; k++) begin
      write_word(18'h3C000 + 18'(k));
      if (k == 6)  check("R7 seven words", {16'h0, fill_status}, 18'h0);
      if (k == 7)  check("R7 eight words", {16'h0, fill_status}, 18'h2);
      if (k == 14) check("R7 fifteen words", {16'h0, fill_status}, 18'h2);
    end
    check("R7 full code", {16'h0, fill_status}, 18'h3);
    write_word(18'h0DEAD);
    check("R6 full after extra", {16'h0, fill_status}, 18'h3);
    check("R6 head kept", out_word, 18'h3C000);
    set_strobe(1'b0);
    for (int k = 1; k < 16; k++) begin
      set_strobe(1'b1);
      check("R5 advance", out_word, 18'h3C000 + 18'(k));
      if (k == 1) check("R7 fifteen after read", {16'h0, fill_status}, 18'h2);
      if (k == 9) check("R7 seven after reads", {16'h0, fill_status}, 18'h0);
      set_strobe(1'b0);
    end
    check("R6 extra word never stored", out_word, 18'h3C00F);
    check("R8 empty after final fall", {16'h0, fill_status}, 18'h1);
  endtask

  task automatic t_clear;
    set_strobe(1'b1);
    write_word(18'h22221);
    write_word(18'h22222);
    write_word(18'h22223);
    set_mode(1'b0);
    check("R10 bypass with strobe high keeps", {16'h0, fill_status}, 18'h0);
    set_strobe(1'b0);
    check("R10 cleared", {16'h0, fill_status}, 18'h1);
    set_strobe(1'b1);
    set_mode(1'b1);
    check("R10 stays empty", {16'h0, fill_status}, 18'h1);
    write_word(18'h04444);
    check("R10 new head after clear", out_word, 18'h04444);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(4);
    t_reset();
    t_bypass();
    t_show_ahead();
    t_full();
    t_clear();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule